// File: doc/BRIEF.md
# Breakpoint Acknowledge Bus Sequencer

When a breakpoint instruction executes, this block runs one breakpoint acknowledge read on an asynchronous bus. A start pulse brings in a 3-bit breakpoint number. The sequencer drives a read in CPU address space with the breakpoint number on the address lines, raises the address and data strobes, and waits for the responder to terminate the access. If the responder supplies data, the sequencer hands a 16-bit replacement instruction word back to the pipeline in place of the breakpoint opcode. If the responder signals a bus error, the sequencer raises an illegal-instruction exception request.

A responder on a byte-wide port returns only eight bits per access. In that case the sequencer runs a second access at the odd byte address and builds the full word from the two bytes. Before it moves on after any access, it waits until the responder has released every termination line. The result is a single-cycle pulse, either the word or the exception request. One cycle of done follows, and then the block returns to idle.

Top module: `bkpt_ack_seq`

## Requirements
- R1: During reset and while idle, as_o, ds_o, word_valid, illegal_instr and done are low, and fc, addr, size and rw_o are all zero.
- R2: A start pulse seen in idle launches a cycle. In the next cycle the bus fields are driven with both strobes low. In the cycle after that, as_o and ds_o are both high.
- R3: While a cycle is driven, fc is 3'b111, rw_o is 1 (read) and size is 2'b10 (word). addr[19:16] is 0 and addr[4:2] holds the breakpoint number captured at start. addr[0] is 1 only on the second byte access. Every other address bit is 0, and the address does not change while the strobes are high.
- R4: A 16-bit acknowledge (dsack[0] = 1, berr low) latches data_in[15:0] as the word. Both strobes are low in the next cycle.
- R5: An 8-bit acknowledge (dsack = 2'b10, berr low) on the first access stores data_in[15:8] as word[15:8] and runs a second access. On the second access, any acknowledge stores data_in[15:8] as word[7:0].
- R6: berr takes priority over dsack on either access. It negates both strobes in the next cycle, and the cycle ends with an illegal_instr pulse and no word_valid.
- R7: After the strobes negate, the sequencer stays put until dsack is 2'b00 and berr is low. It starts no access and produces no result while either line is still held.
- R8: Once the responder releases, a successful cycle gives word_valid for exactly one cycle with the assembled word on `word`, and a failed cycle gives illegal_instr for exactly one cycle. The following cycle pulses done, and then the block is idle.
- R9: A start pulse while a cycle is in progress has no effect. The breakpoint number on the bus stays the one captured at launch, and no further cycle follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse from breakpoint execution |
| bp_num | input | 3 | Breakpoint number, sampled with start |
| fc | output | 3 | Function code (3'b111 = CPU space) |
| addr | output | 32 | Bus address |
| size | output | 2 | Transfer size (2'b10 = word) |
| rw_o | output | 1 | 1 = read |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |
| dsack | input | 2 | Acknowledge: bit0 = 16-bit port, 2'b10 = 8-bit port |
| berr | input | 1 | Bus error termination |
| data_in | input | 16 | Bus read data |
| word | output | 16 | Replacement instruction word |
| word_valid | output | 1 | One-cycle pulse: word is valid |
| illegal_instr | output | 1 | One-cycle illegal-instruction request |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A byte that lands in the wrong half of the word, or a lost second-access flag, shows up in the value of `word`, or as a missing odd-address access, in the same cycle as word_valid. A control state that does not advance or that skips a step shows at the strobes within one cycle of the responder's action. A premature restart shows as as_o rising while dsack or berr is still held. A stale error flag turns a good cycle into an illegal_instr pulse. A mis-captured breakpoint number is visible on addr[4:2] from the first driven cycle.

// File: rtl/bkack_pkg.sv
package bkack_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 16;
  localparam int BPN_W  = 3;
  localparam int BYTE_W = DATA_W / 2;

  localparam logic [2:0] FC_CPU    = 3'b111;
  localparam logic [1:0] SZ_WORD   = 2'b10;
  localparam int         BPN_LSB   = 2;
  localparam int         TYPE_LSB  = 16;
  localparam logic [3:0] TYPE_BKPT = 4'h0;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_STROBE = 3'd2,
    ST_REL    = 3'd3,
    ST_RESULT = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;

  // CPU-space address for one acknowledge access
  function automatic logic [ADDR_W-1:0] bkack_addr(input logic [BPN_W-1:0] bpn,
                                                   input logic odd_byte);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[TYPE_LSB +: 4]        = TYPE_BKPT;
    a[BPN_LSB +: BPN_W]     = bpn;
    a[0]                    = odd_byte;
    return a;
  endfunction
endpackage

// File: rtl/bkack_fsm.sv
module bkack_fsm
  import bkack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] dsack,
  input  logic       berr,
  output logic       launch,
  output logic       drive,
  output logic       strobe,
  output logic       second,
  output logic       err,
  output logic       lat_word,
  output logic       lat_hi,
  output logic       lat_lo,
  output logic       result,
  output logic       fin
);
  seq_state_e state_q, state_d;
  logic second_q, err_q, more_q;
  logic term_err, term_word, term_byte, term_any, released;

  assign term_err  = berr;
  assign term_word = !berr && dsack[0];
  assign term_byte = !berr && (dsack == 2'b10);
  assign term_any  = term_err || term_word || term_byte;
  assign released  = (dsack == 2'b00) && !berr;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_ADDR;
      ST_ADDR:   state_d = ST_STROBE;
      ST_STROBE: if (term_any) state_d = ST_REL;
      ST_REL: begin
        if (released) state_d = (more_q && !err_q) ? ST_ADDR : ST_RESULT;
      end
      ST_RESULT: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      err_q    <= 1'b0;
      more_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        second_q <= 1'b0;
        err_q    <= 1'b0;
        more_q   <= 1'b0;
      end else if (state_q == ST_STROBE) begin
        if (term_err) err_q <= 1'b1;
        if (term_byte && !second_q) more_q <= 1'b1;
      end else if (state_q == ST_REL && released && more_q && !err_q) begin
        second_q <= 1'b1;
        more_q   <= 1'b0;
      end
    end
  end

  assign launch   = (state_q == ST_IDLE) && start;
  assign drive    = (state_q == ST_ADDR) || (state_q == ST_STROBE) || (state_q == ST_REL);
  assign strobe   = (state_q == ST_STROBE);
  assign second   = second_q;
  assign err      = err_q;
  assign lat_word = strobe && !second_q && term_word;
  assign lat_hi   = strobe && !second_q && term_byte;
  assign lat_lo   = strobe && second_q && (term_word || term_byte);
  assign result   = (state_q == ST_RESULT);
  assign fin      = (state_q == ST_DONE);
endmodule

// File: rtl/bkack_addr_gen.sv
module bkack_addr_gen
  import bkack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [BPN_W-1:0]  bp_num,
  input  logic              drive,
  input  logic              second,
  output logic [2:0]        fc,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        size,
  output logic              rw
);
  logic [BPN_W-1:0] bpn_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      bpn_q <= '0;
    else if (launch) bpn_q <= bp_num;
  end

  always_comb begin
    fc   = drive ? FC_CPU  : 3'b000;
    size = drive ? SZ_WORD : 2'b00;
    rw   = drive;
    addr = drive ? bkack_addr(bpn_q, second) : '0;
  end
endmodule

// File: rtl/bkack_word_asm.sv
module bkack_word_asm
  import bkack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              lat_word,
  input  logic              lat_hi,
  input  logic              lat_lo,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] word
);
  logic [BYTE_W-1:0] lane_q [2];
  logic [BYTE_W-1:0] byte_lane;

  // byte-wide responders present their byte on the upper lane
  assign byte_lane = data_in[DATA_W-1 -: BYTE_W];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic take_byte;
    assign take_byte = (g == 1) ? lat_hi : lat_lo;
    always_ff @(posedge clk) begin
      if (!rst_n || launch) lane_q[g] <= '0;
      else if (lat_word)    lane_q[g] <= data_in[g*BYTE_W +: BYTE_W];
      else if (take_byte)   lane_q[g] <= byte_lane;
    end
  end

  assign word = {lane_q[1], lane_q[0]};
endmodule

// File: rtl/bkpt_ack_seq.sv
module bkpt_ack_seq
  import bkack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BPN_W-1:0]  bp_num,
  output logic [2:0]        fc,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        size,
  output logic              rw_o,
  output logic              as_o,
  output logic              ds_o,
  input  logic [1:0]        dsack,
  input  logic              berr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] word,
  output logic              word_valid,
  output logic              illegal_instr,
  output logic              done
);
  logic launch_ev, drive_en, strobe_en, second_acc, err_seen;
  logic lat_word_ev, lat_hi_ev, lat_lo_ev, result_fire, fin_ev;

  bkack_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dsack    (dsack),
    .berr     (berr),
    .launch   (launch_ev),
    .drive    (drive_en),
    .strobe   (strobe_en),
    .second   (second_acc),
    .err      (err_seen),
    .lat_word (lat_word_ev),
    .lat_hi   (lat_hi_ev),
    .lat_lo   (lat_lo_ev),
    .result   (result_fire),
    .fin      (fin_ev)
  );

  bkack_addr_gen u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch_ev),
    .bp_num (bp_num),
    .drive  (drive_en),
    .second (second_acc),
    .fc     (fc),
    .addr   (addr),
    .size   (size),
    .rw     (rw_o)
  );

  bkack_word_asm u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch_ev),
    .lat_word (lat_word_ev),
    .lat_hi   (lat_hi_ev),
    .lat_lo   (lat_lo_ev),
    .data_in  (data_in),
    .word     (word)
  );

  assign as_o          = strobe_en;
  assign ds_o          = strobe_en;
  assign word_valid    = result_fire && !err_seen;
  assign illegal_instr = result_fire && err_seen;
  assign done          = fin_ev;
endmodule

// File: rtl/bkpt_ack_seq_chk.sv
module bkpt_ack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        as_o,
  input logic        ds_o,
  input logic [2:0]  fc,
  input logic [31:0] addr,
  input logic [1:0]  size,
  input logic        rw_o,
  input logic [1:0]  dsack,
  input logic        berr,
  input logic        word_valid,
  input logic        illegal_instr,
  input logic        done
);
  // R3
  cpu_space_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |-> (fc == 3'b111 && rw_o && size == 2'b10 && addr[19:16] == 4'h0));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_o && $past(as_o)) |-> $stable(addr));

  // R7
  restart_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_o) |-> (dsack == 2'b00 && !berr));

  // R6
  result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && illegal_instr));

  // R8
  done_follows_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid || illegal_instr) |=> (done && !word_valid && !illegal_instr));

  // R8
  no_strobe_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid || illegal_instr || done) |-> (!as_o && !ds_o));

  // R4
  strobes_drop_on_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_o && (berr || dsack != 2'b00)) |=> !as_o);
endmodule

bind bkpt_ack_seq bkpt_ack_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .as_o          (as_o),
  .ds_o          (ds_o),
  .fc            (fc),
  .addr          (addr),
  .size          (size),
  .rw_o          (rw_o),
  .dsack         (dsack),
  .berr          (berr),
  .word_valid    (word_valid),
  .illegal_instr (illegal_instr),
  .done          (done)
);

// File: tb/bkpt_ack_seq_tb.sv
module bkpt_ack_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  bp_num = '0;
  logic [2:0]  fc;
  logic [31:0] addr;
  logic [1:0]  size;
  logic        rw_o, as_o, ds_o;
  logic [1:0]  dsack = 2'b00;
  logic        berr = 1'b0;
  logic [15:0] data_in = '0;
  logic [15:0] word;
  logic        word_valid, illegal_instr, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  bkpt_ack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bp_num(bp_num),
    .fc(fc), .addr(addr), .size(size), .rw_o(rw_o), .as_o(as_o), .ds_o(ds_o),
    .dsack(dsack), .berr(berr), .data_in(data_in), .word(word),
    .word_valid(word_valid), .illegal_instr(illegal_instr), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [2:0] b, input bit odd);
    return (32'(b) * 32'd4) + (odd ? 32'd1 : 32'd0);
  endfunction

  task automatic check_idle(input string req);
    chk(!as_o && !ds_o && !word_valid && !illegal_instr && !done, req,
        {27'd0, as_o, ds_o, word_valid, illegal_instr, done}, 32'd0);
    chk(fc == 0 && addr == 0 && size == 0 && !rw_o, req, addr, 32'd0);
  endtask

  // one access: expects strobes up, drives the termination, releases after hold
  task automatic access(input logic [2:0] b, input bit odd, input int kind,
                        input logic [15:0] d, input int hold, input bit poke);
    // ADDR cycle
    chk(!as_o && !ds_o, "R2 strobes low in address cycle", {31'd0, as_o}, 32'd0);
    chk(addr == exp_addr(b, odd), "R3 address", addr, exp_addr(b, odd));
    chk(fc == 3'b111 && rw_o && size == 2'b10, "R3 fc/rw/size",
        {26'd0, fc, rw_o, size}, {26'd0, 3'b111, 1'b1, 2'b10});
    @(negedge clk);
    chk(as_o && ds_o, "R2 strobes high", {30'd0, as_o, ds_o}, 32'd3);
    if (poke) begin
      start = 1'b1; bp_num = ~b;          // R9 start while busy
      @(negedge clk);
      start = 1'b0;
      chk(as_o && addr == exp_addr(b, odd), "R9 start ignored while busy",
          addr, exp_addr(b, odd));
    end
    @(negedge clk);
    chk(as_o, "R2 strobes held awaiting termination", {31'd0, as_o}, 32'd1);
    // kind: 0 = 16-bit ack, 1 = 8-bit ack, 2 = berr, 3 = berr with dsack
    dsack = (kind == 0) ? 2'b01 : (kind == 1) ? 2'b10 : (kind == 3) ? 2'b01 : 2'b00;
    berr  = (kind >= 2);
    data_in = d;
    @(negedge clk);
    chk(!as_o && !ds_o, (kind >= 2) ? "R6 strobes drop on berr" : "R4 strobes drop on ack",
        {30'd0, as_o, ds_o}, 32'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(!as_o && !word_valid && !illegal_instr && !done, "R7 wait for release",
          {29'd0, as_o, word_valid, illegal_instr}, 32'd0);
    end
    dsack = 2'b00; berr = 1'b0; data_in = 16'hDEAD;
    @(negedge clk);
  endtask

  // err_at: 0 none, 1 first access, 2 second access
  task automatic run_bkpt(input string name, input logic [2:0] b, input bit byte_port,
                          input int err_at, input bit err_with_ack, input int hold,
                          input bit poke, input logic [15:0] d0, input logic [15:0] d1);
    logic [15:0] expw;
    bit fail;
    fail = (err_at != 0);
    expw = byte_port ? {d0[15:8], d1[15:8]} : d0;
    start = 1'b1; bp_num = b;
    @(negedge clk);
    start = 1'b0; bp_num = 3'd0;
    access(b, 1'b0, (err_at == 1) ? (err_with_ack ? 3 : 2) : (byte_port ? 1 : 0),
           d0, hold, poke);
    if (byte_port && err_at != 1) begin
      chk(addr == exp_addr(b, 1'b1), "R5 second access at odd address", addr,
          exp_addr(b, 1'b1));
      access(b, 1'b1, (err_at == 2) ? 2 : 1, d1, hold, 1'b0);
    end
    if (fail) begin
      chk(illegal_instr && !word_valid, "R6 illegal_instr pulse",
          {30'd0, illegal_instr, word_valid}, 32'd2);
    end else begin
      chk(word_valid && !illegal_instr, "R8 word_valid pulse",
          {30'd0, word_valid, illegal_instr}, 32'd2);
      chk(word == expw, byte_port ? "R5 byte assembly" : "R4 word latch", word, expw);
    end
    @(negedge clk);
    chk(done && !word_valid && !illegal_instr, "R8 done after result",
        {29'd0, done, word_valid, illegal_instr}, 32'd4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_idle(poke ? "R9 no cycle after ignored start" : "R8 idle after done");
    end
    $display("scenario %s finished", name);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b1; bp_num = 3'd6;
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    run_bkpt("word port",            3'd5, 1'b0, 0, 1'b0, 0, 1'b0, 16'hA55A, 16'h0000);
    run_bkpt("byte port",            3'd3, 1'b1, 0, 1'b0, 0, 1'b0, 16'h12FF, 16'h34EE);
    run_bkpt("berr first",           3'd7, 1'b0, 1, 1'b0, 0, 1'b0, 16'h1111, 16'h0000);
    run_bkpt("berr beats dsack",     3'd2, 1'b0, 1, 1'b1, 0, 1'b0, 16'h2222, 16'h0000);
    run_bkpt("berr second byte",     3'd1, 1'b1, 2, 1'b0, 0, 1'b0, 16'h5600, 16'h7800);
    run_bkpt("slow release word",    3'd0, 1'b0, 0, 1'b0, 4, 1'b0, 16'hBEEF, 16'h0000);
    run_bkpt("slow release byte",    3'd6, 1'b1, 0, 1'b0, 3, 1'b0, 16'hC300, 16'h3C00);
    run_bkpt("start while busy",     3'd4, 1'b0, 0, 1'b0, 0, 1'b1, 16'h0F0F, 16'h0000);
    run_bkpt("back to back",         3'd7, 1'b1, 0, 1'b0, 0, 1'b0, 16'h8000, 16'h0100);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule